// File: doc/BRIEF.md
# Pipelined Signed Multiply-Accumulate Unit

This block multiplies two signed two's-complement operands and keeps a running two's-complement sum of the products. Only the high half of each product is kept. With the default widths the 16-bit product is cut to its upper 8 bits. That byte is sign-extended to the width of the accumulator and added to the stored sum. A register stage sits between the multiplier and the adder, so multiplication and accumulation each take one clock stage. A new operand pair can be issued every cycle.

The accumulator wraps modulo 2^16. A sticky flag records any signed overflow of the sum. A clear input zeroes the sum and the flag and discards any product still in the pipeline. When the enable input is low, the operand pair in that cycle contributes nothing.

Top module: `prod_accum_unit`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it rises, `acc_sum` is 0 and `ovf_flag` is 0.
- R2: An operand pair sampled with `acc_en`=1 and `clr`=0 at clock edge k changes `acc_sum` at edge k+1. Two edges after the pair is presented, `acc_sum` equals the previous sum plus that pair's truncated product.
- R3: The truncated product is floor(a*b/256), where `op_a` and `op_b` are signed 8-bit values. It is the upper byte [15:8] of the 16-bit signed product. Examples: 1*(-1) adds -1, and 64*4 adds 1.
- R4: The truncated byte is sign-extended before the addition, so a negative byte lowers the sum. For example, (-128)*127 adds -64.
- R5: An operand pair sampled with `acc_en`=0 adds nothing. If no enabled pair is in flight, `acc_sum` holds its value.
- R6: When `clr` is sampled high, `acc_sum` and `ovf_flag` become 0 on that edge. A pair sampled one edge earlier is discarded and is never added.
- R7: The sum wraps modulo 2^16. For example, 32767 + 1 gives -32768.
- R8: `ovf_flag` rises when an addition has two addends of equal sign and a result of the other sign. It stays high until `clr` or reset.
- R9: A pair sampled in the same edge as `clr`=1 is discarded even if `acc_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Accept the operand pair of this cycle |
| clr | input | 1 | Zero the sum and flag, and flush the pipeline |
| op_a | input | 8 | Signed multiplicand |
| op_b | input | 8 | Signed multiplier |
| acc_sum | output | 16 | Running signed sum |
| ovf_flag | output | 1 | Sticky signed-overflow flag |

## Verification
A wrong product byte or a lost valid bit in the pipeline register shows as a wrong `acc_sum` at the second edge after the pair is presented. It then stays wrong, because the error is carried into every later sum. A faulty carry into the top bit shows as a missing or spurious `ovf_flag` on the same edge as the bad sum. The bench sweeps every signed operand pair and runs a long overflow run, comparing both outputs every cycle against an arithmetic model.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
  localparam int DEF_OP_W  = 8;
  localparam int DEF_ACC_W = 16;

  // Action taken by the accumulator register on an edge
  typedef enum logic [1:0] {
    ACC_HOLD = 2'd0,
    ACC_ADD  = 2'd1,
    ACC_ZERO = 2'd2
  } acc_act_e;
endpackage

// File: rtl/mac_full_add.sv
`timescale 1ns/1ps
module mac_full_add (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = a_i ^ b_i ^ c_i;
  assign c_o = (a_i & b_i) | (c_i & (a_i ^ b_i));
endmodule

// File: rtl/mac_mult_stage.sv
`timescale 1ns/1ps
module mac_mult_stage #(
  parameter int OP_W = mac_pkg::DEF_OP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_en,
  input  logic            clr,
  input  logic [OP_W-1:0] op_a,
  input  logic [OP_W-1:0] op_b,
  output logic            pipe_vld,
  output logic [OP_W-1:0] pipe_hi
);
  localparam int PROD_W = 2 * OP_W;

  logic signed [PROD_W-1:0] a_ext;
  logic signed [PROD_W-1:0] pp [OP_W];
  logic signed [PROD_W-1:0] prod;
  logic [OP_W-1:0]          hi_nxt;
  logic                     vld_nxt;
  logic                     unused_lo;

  assign a_ext = PROD_W'(signed'(op_a));

  // Partial product rows; the top operand bit carries negative weight
  for (genvar i = 0; i < OP_W; i++) begin : g_row
    if (i == OP_W - 1) begin : g_neg
      assign pp[i] = op_b[i] ? -(a_ext <<< i) : '0;
    end else begin : g_pos
      assign pp[i] = op_b[i] ? (a_ext <<< i) : '0;
    end
  end

  always_comb begin
    prod = '0;
    for (int i = 0; i < OP_W; i++) begin
      prod = prod + pp[i];
    end
  end

  assign hi_nxt    = prod[PROD_W-1 -: OP_W];
  assign unused_lo = ^prod[OP_W-1:0];
  assign vld_nxt   = acc_en & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_vld <= 1'b0;
      pipe_hi  <= '0;
    end else begin
      pipe_vld <= vld_nxt;
      if (vld_nxt) begin
        pipe_hi <= hi_nxt;
      end
    end
  end
endmodule

// File: rtl/mac_acc_stage.sv
`timescale 1ns/1ps
module mac_acc_stage
  import mac_pkg::*;
#(
  parameter int OP_W  = DEF_OP_W,
  parameter int ACC_W = DEF_ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             pipe_vld,
  input  logic [OP_W-1:0]  pipe_hi,
  output logic [ACC_W-1:0] acc_q,
  output logic             ovf_q
);
  localparam int EXT_W = ACC_W - OP_W;

  logic [ACC_W-1:0] addend;
  logic [ACC_W-1:0] sum;
  logic [ACC_W:0]   carry;
  logic             ovf_add;
  acc_act_e         act;
  logic [ACC_W-1:0] acc_d;
  logic             ovf_d;
  logic             ld_en;

  assign addend   = {{EXT_W{pipe_hi[OP_W-1]}}, pipe_hi};
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < ACC_W; i++) begin : g_bit
    mac_full_add fa_i (
      .a_i (acc_q[i]),
      .b_i (addend[i]),
      .c_i (carry[i]),
      .s_o (sum[i]),
      .c_o (carry[i+1])
    );
  end

  // Signed overflow: carry into the top bit differs from carry out
  assign ovf_add = carry[ACC_W] ^ carry[ACC_W-1];

  always_comb begin
    if (clr) begin
      act = ACC_ZERO;
    end else if (pipe_vld) begin
      act = ACC_ADD;
    end else begin
      act = ACC_HOLD;
    end
  end

  always_comb begin
    acc_d = acc_q;
    ovf_d = ovf_q;
    unique case (act)
      ACC_ZERO: begin
        acc_d = '0;
        ovf_d = 1'b0;
      end
      ACC_ADD: begin
        acc_d = sum;
        ovf_d = ovf_q | ovf_add;
      end
      default: begin
        acc_d = acc_q;
        ovf_d = ovf_q;
      end
    endcase
  end

  assign ld_en = (act != ACC_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (ld_en) begin
      acc_q <= acc_d;
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/prod_accum_unit.sv
`timescale 1ns/1ps
module prod_accum_unit #(
  parameter int OP_W  = mac_pkg::DEF_OP_W,
  parameter int ACC_W = mac_pkg::DEF_ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             clr,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  output logic [ACC_W-1:0] acc_sum,
  output logic             ovf_flag
);
  logic            pipe_vld;
  logic [OP_W-1:0] pipe_hi;

  mac_mult_stage #(.OP_W(OP_W)) mult_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (acc_en),
    .clr      (clr),
    .op_a     (op_a),
    .op_b     (op_b),
    .pipe_vld (pipe_vld),
    .pipe_hi  (pipe_hi)
  );

  mac_acc_stage #(.OP_W(OP_W), .ACC_W(ACC_W)) acc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .pipe_vld (pipe_vld),
    .pipe_hi  (pipe_hi),
    .acc_q    (acc_sum),
    .ovf_q    (ovf_flag)
  );
endmodule

// File: rtl/prod_accum_unit_chk.sv
`timescale 1ns/1ps
module prod_accum_unit_chk #(
  parameter int OP_W  = 8,
  parameter int ACC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_en,
  input logic             clr,
  input logic [ACC_W-1:0] acc_sum,
  input logic             ovf_flag,
  input logic             pipe_vld,
  input logic [OP_W-1:0]  pipe_hi
);
  logic [ACC_W-1:0] chk_ext;
  assign chk_ext = {{(ACC_W-OP_W){pipe_hi[OP_W-1]}}, pipe_hi};

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_sum == '0) && !ovf_flag);  // R6

  AST_CLEAR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pipe_vld);  // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !$past(acc_en)) |=> $stable(acc_sum));  // R5

  AST_ACCUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_vld && !clr) |=> acc_sum == $past(acc_sum) + $past(chk_ext));  // R2

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr) |=> ovf_flag);  // R8

  AST_OVF_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_vld && !clr && !ovf_flag && (pipe_hi[OP_W-1] == acc_sum[ACC_W-1]))
    |=> ovf_flag == (acc_sum[ACC_W-1] != $past(acc_sum[ACC_W-1])));  // R8
endmodule

bind prod_accum_unit prod_accum_unit_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_en   (acc_en),
  .clr      (clr),
  .acc_sum  (acc_sum),
  .ovf_flag (ovf_flag),
  .pipe_vld (pipe_vld),
  .pipe_hi  (pipe_hi)
);

// File: tb/prod_accum_unit_tb_top.sv
`timescale 1ns/1ps
module prod_accum_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic        acc_en;
  logic        clr;
  logic [7:0]  op_a;
  logic [7:0]  op_b;
  logic [15:0] acc_sum;
  logic        ovf_flag;

  int n_chk;
  int n_bad;
  int cyc;

  // reference model state
  int   m_acc;
  logic m_ovf;
  logic m_vld;
  int   m_hi;

  prod_accum_unit dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (acc_en),
    .clr      (clr),
    .op_a     (op_a),
    .op_b     (op_b),
    .acc_sum  (acc_sum),
    .ovf_flag (ovf_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag);
    int got;
    got = int'(signed'(acc_sum));
    n_chk++;
    if (got != m_acc || ovf_flag !== m_ovf) begin
      n_bad++;
      $display("FAIL %s acc=%0d exp=%0d ovf=%0b exp=%0b", tag, got, m_acc, ovf_flag, m_ovf);
    end
  endtask

  // drive one cycle, advance model at the edge, check at the falling edge
  task automatic step(input logic en, input logic c, input logic [7:0] a,
                      input logic [7:0] b, input string tag);
    int s;
    acc_en = en;
    clr    = c;
    op_a   = a;
    op_b   = b;
    @(posedge clk);
    if (c) begin
      m_acc = 0;
      m_ovf = 1'b0;
    end else if (m_vld) begin
      s = m_acc + m_hi;
      if (s > 32767 || s < -32768) m_ovf = 1'b1;
      m_acc = int'(signed'(16'(s)));
    end
    m_vld = en && !c;
    m_hi  = (int'(signed'(a)) * int'(signed'(b))) >>> 8;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    cyc = 0;
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired acc=%0d exp=%0d", acc_sum, m_acc);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    m_acc = 0; m_ovf = 0; m_vld = 0; m_hi = 0;
    rst_n = 1'b0; acc_en = 0; clr = 0; op_a = 0; op_b = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // truncation and sign extension, each observed two edges later
    step(1, 0, 8'd1,   8'hFF, "R3 issue 1*-1");
    step(0, 0, 8'd0,   8'd0,  "R3 1*-1 adds -1");
    step(1, 0, 8'd64,  8'd4,  "R2 issue 64*4");
    step(0, 0, 8'd0,   8'd0,  "R2 64*4 adds 1");
    step(1, 0, 8'h80,  8'd127,"R4 issue -128*127");
    step(0, 0, 8'd0,   8'd0,  "R4 adds -64");
    step(1, 0, 8'd100, 8'd100,"R2 back to back a");
    step(1, 0, 8'h9C,  8'd50, "R2 back to back b");
    step(0, 0, 8'd0,   8'd0,  "R2 back to back drain");

    // disabled pairs add nothing
    for (int i = 0; i < 5; i++) step(0, 0, 8'd120, 8'd120, "R5 idle hold");

    // clear discards in-flight and same-cycle pairs
    step(1, 0, 8'd90,  8'd90, "R6 issue before clear");
    step(1, 1, 8'd90,  8'd90, "R6 R9 clear");
    step(0, 0, 8'd0,   8'd0,  "R9 nothing added after clear");

    // long positive run: wraps and raises the sticky flag
    for (int i = 0; i < 520; i++) step(1, 0, 8'h80, 8'h80, "R7 R8 overflow run");
    for (int i = 0; i < 4; i++)   step(0, 0, 8'd0,  8'd0,  "R8 sticky flag");
    step(0, 1, 8'd0, 8'd0, "R6 clear drops flag");

    // exhaustive sweep of all signed operand pairs
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        step(1, 0, 8'(a), 8'(b), "R2 sweep");
      end
    end
    step(0, 0, 8'd0, 8'd0, "R2 sweep drain");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule